// File: doc/BRIEF.md
# Rate-Coded Pseudo-Random Fault Trigger

This block decides, cycle by cycle, whether a fault should be injected into some downstream datapath. It raises a single-cycle `fire` pulse whose long-run frequency is selected by a 4-bit rate code. Two 16-bit maximal-length shift-register generators run side by side from different seeds. Each cycle, the low `n` bits of the two generators are compared, where `n` is the rate code. A trigger is issued only when every compared bit agrees. Each step up in the code therefore halves the trigger rate.

The all-ones code does not use the random comparison. It selects the permanent-fault mode, which the block reports on `perm_mode`. In that mode `fire` is asserted on every enabled cycle. The all-zeros code never triggers. The code may change at any time, and the new rate applies from the next comparison without reseeding. Reset clears every register. A `load` strobe, issued after reset, loads both seeds.

Top module: `fr_trigger`

## Requirements
- R1: While `rst` is high, and on the cycle after it, `fire` and `perm_mode` are 0. After reset, `fire` stays 0 until the first `load` strobe has been accepted.
- R2: Each generator advances on every clock edge that has neither `rst` nor `load`. The next state is `{s[14:0], s[15]^s[13]^s[12]^s[10]}` (polynomial x^16+x^14+x^13+x^11+1). On a `load` edge, generator A takes `seed_a` and generator B takes `seed_b`.
- R3: A zero seed is replaced on load by a nonzero default: 16'hACE1 for A and 16'h5A3C for B. After a load, neither generator state is ever zero.
- R4: For a rate code n from 1 to 14, `fire` is high in the cycle after an edge exactly when `en` was high, the block was seeded, and bits [n-1:0] of the two generator states before that edge were equal.
- R5: With seeds that differ, for code n from 1 to 14 the measured trigger count over a window of N cycles lies near N/2^n.
- R6: Rate code 0 never raises `fire`.
- R7: Rate code 15 (all ones) sets `perm_mode` to 1 one cycle later. With `en` high and the block seeded, it also raises `fire` on every cycle, independent of the generator bits.
- R8: With `en` low, `fire` is 0 on the next cycle, while both generators keep advancing.
- R9: A change of rate code applies to the very next comparison, with no reload.
- R10: `fire` and `perm_mode` are registered. Each reflects the inputs and generator states present before the preceding clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; clears all registers |
| load | input | 1 | Loads both generator seeds on this edge |
| seed_a | input | 16 | Seed for generator A (0 selects the default) |
| seed_b | input | 16 | Seed for generator B (0 selects the default) |
| en | input | 1 | Allows triggers to be issued |
| rate_code | input | 4 | 0 = off, 1..14 = rate 2^-n, 15 = permanent mode |
| fire | output | 1 | One-cycle fault trigger |
| perm_mode | output | 1 | High while the previous code was the permanent-fault code |

## Verification
A wrong feedback tap, a wrong seed substitution, or a missed advance puts a generator on a different point of its sequence. This shows up at `fire` within a handful of cycles under code 1, because about half of all cycles depend on one bit of each generator. The bench therefore keeps its own model of both generators, derived from the stated polynomial, and compares `fire` on every cycle. A mask that is one bit too wide or too narrow gives exact-sequence mismatches, and the windowed counts also drift by a factor of two. Mode decoding faults appear on the first cycle after code 0 or 15 is applied.

// File: rtl/fr_pkg.sv
package fr_pkg;

    localparam int LFSR_W = 16;
    localparam int CODE_W = 4;
    localparam logic [CODE_W-1:0] CODE_OFF  = '0;
    localparam logic [CODE_W-1:0] CODE_PERM = '1;
    localparam logic [LFSR_W-1:0] FB_TAPS   = 16'hB400;

    typedef logic [LFSR_W-1:0] lfsr_t;
    typedef logic [CODE_W-1:0] code_t;

    typedef enum logic [1:0] {
        RM_OFF    = 2'd0,
        RM_RANDOM = 2'd1,
        RM_PERM   = 2'd2
    } rate_mode_e;

    typedef struct packed {
        rate_mode_e mode;
        lfsr_t      mask;
    } rate_cfg_t;

    // One Fibonacci step: shift toward the MSB, feed parity of tapped bits in.
    function automatic lfsr_t lfsr_step(input lfsr_t s, input lfsr_t taps);
        return {s[LFSR_W-2:0], ^(s & taps)};
    endfunction

    // Thermometer mask with the low 'code' bits set.
    function automatic lfsr_t low_mask(input code_t code);
        lfsr_t m;
        for (int i = 0; i < LFSR_W; i++) begin
            m[i] = (i < int'(code));
        end
        return m;
    endfunction

endpackage

// File: rtl/fr_lfsr.sv
module fr_lfsr
    import fr_pkg::*;
#(
    parameter lfsr_t TAPS         = FB_TAPS,
    parameter lfsr_t DEFAULT_SEED = 16'hACE1
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  lfsr_t seed,
    output lfsr_t state
);

    lfsr_t state_q;
    lfsr_t seed_eff;

    assign seed_eff = (seed == '0) ? DEFAULT_SEED : seed;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else if (load) begin
            state_q <= seed_eff;
        end else begin
            state_q <= lfsr_step(state_q, TAPS);
        end
    end

    assign state = state_q;

endmodule

// File: rtl/fr_rate_decode.sv
module fr_rate_decode
    import fr_pkg::*;
(
    input  code_t     code,
    output rate_cfg_t cfg
);

    always_comb begin
        cfg.mask = '0;
        if (code == CODE_OFF) begin
            cfg.mode = RM_OFF;
        end else if (code == CODE_PERM) begin
            cfg.mode = RM_PERM;
        end else begin
            cfg.mode = RM_RANDOM;
            cfg.mask = low_mask(code);
        end
    end

endmodule

// File: rtl/fr_match.sv
module fr_match
    import fr_pkg::*;
(
    input  lfsr_t a,
    input  lfsr_t b,
    input  lfsr_t mask,
    output logic  equal
);

    lfsr_t diff;

    for (genvar i = 0; i < LFSR_W; i++) begin : g_bit
        assign diff[i] = (a[i] ^ b[i]) & mask[i];
    end

    assign equal = ~|diff;

endmodule

// File: rtl/fr_trigger.sv
module fr_trigger
    import fr_pkg::*;
#(
    parameter lfsr_t DEFAULT_SEED_A = 16'hACE1,
    parameter lfsr_t DEFAULT_SEED_B = 16'h5A3C
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  logic [15:0] seed_a,
    input  logic [15:0] seed_b,
    input  logic        en,
    input  logic [3:0]  rate_code,
    output logic        fire,
    output logic        perm_mode
);

    localparam int N_GEN = 2;

    lfsr_t     seeds [N_GEN];
    lfsr_t     st    [N_GEN];
    lfsr_t     state_a;
    lfsr_t     state_b;
    rate_cfg_t cfg;
    logic      bits_equal;
    logic      seeded_q;
    logic      fire_q;
    logic      perm_q;
    logic      fire_d;

    assign seeds[0] = seed_a;
    assign seeds[1] = seed_b;

    for (genvar g = 0; g < N_GEN; g++) begin : g_gen
        fr_lfsr #(
            .TAPS        (FB_TAPS),
            .DEFAULT_SEED((g == 0) ? DEFAULT_SEED_A : DEFAULT_SEED_B)
        ) u_lfsr (
            .clk  (clk),
            .rst  (rst),
            .load (load),
            .seed (seeds[g]),
            .state(st[g])
        );
    end

    assign state_a = st[0];
    assign state_b = st[1];

    fr_rate_decode u_decode (
        .code(rate_code),
        .cfg (cfg)
    );

    fr_match u_match (
        .a    (state_a),
        .b    (state_b),
        .mask (cfg.mask),
        .equal(bits_equal)
    );

    always_comb begin
        unique case (cfg.mode)
            RM_PERM:   fire_d = 1'b1;
            RM_RANDOM: fire_d = bits_equal;
            default:   fire_d = 1'b0;
        endcase
        fire_d = fire_d & en & seeded_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seeded_q <= 1'b0;
            fire_q   <= 1'b0;
            perm_q   <= 1'b0;
        end else begin
            if (load) begin
                seeded_q <= 1'b1;
            end
            fire_q <= fire_d;
            perm_q <= (cfg.mode == RM_PERM);
        end
    end

    assign fire      = fire_q;
    assign perm_mode = perm_q;

endmodule

// File: rtl/fr_trigger_chk.sv
module fr_trigger_chk (
    input logic        clk,
    input logic        rst,
    input logic        load,
    input logic        en,
    input logic [3:0]  rate_code,
    input logic        fire,
    input logic        perm_mode,
    input logic        seeded,
    input logic [15:0] state_a,
    input logic [15:0] state_b
);

    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |=> (!fire && !perm_mode));

    p_unseeded_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !seeded |=> !fire);

    p_state_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
        seeded |-> (state_a != 16'h0 && state_b != 16'h0));

    p_load_nonzero_r2: assert property (@(posedge clk) disable iff (rst)
        load |=> (state_a != 16'h0 && state_b != 16'h0));

    p_code_off_r6: assert property (@(posedge clk) disable iff (rst)
        (rate_code == 4'h0) |=> !fire);

    p_perm_flag_r7: assert property (@(posedge clk) disable iff (rst)
        (rate_code == 4'hF) |=> perm_mode);

    p_perm_fire_r7: assert property (@(posedge clk) disable iff (rst)
        (rate_code == 4'hF && en && seeded) |=> fire);

    p_disabled_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        !en |=> !fire);

    p_flag_tracks_r10: assert property (@(posedge clk) disable iff (rst)
        (rate_code != 4'hF) |=> !perm_mode);

endmodule

bind fr_trigger fr_trigger_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .en       (en),
    .rate_code(rate_code),
    .fire     (fire),
    .perm_mode(perm_mode),
    .seeded   (seeded_q),
    .state_a  (state_a),
    .state_b  (state_b)
);

// File: tb/fr_trigger_bench.sv
`timescale 1ns/1ps
module fr_trigger_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load = 1'b0;
    logic [15:0] seed_a = 16'h0;
    logic [15:0] seed_b = 16'h0;
    logic        en = 1'b0;
    logic [3:0]  rate_code = 4'h0;
    logic        fire;
    logic        perm_mode;

    int total = 0;
    int bad = 0;

    // bench-side model of the two generators
    logic [15:0] ma = 16'h0;
    logic [15:0] mb = 16'h0;
    logic        m_seeded = 1'b0;
    logic        m_perm = 1'b0;

    always #2.5 clk = ~clk;

    fr_trigger u_fr_trigger (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .seed_a   (seed_a),
        .seed_b   (seed_b),
        .en       (en),
        .rate_code(rate_code),
        .fire     (fire),
        .perm_mode(perm_mode)
    );

    typedef struct packed {
        logic [3:0] code;
        int         cycles;
        int         lo;
        int         hi;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{4'd1,  4096,  1700, 2400},
        '{4'd2,  4096,   800, 1250},
        '{4'd3,  4096,   350,  680},
        '{4'd5,  8192,   150,  370},
        '{4'd7,  16384,   60,  200},
        '{4'd14, 2048,     0,    5}
    };

    function automatic logic [15:0] nxt(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    function automatic logic exp_fire(input logic [3:0] c, input logic e);
        logic [15:0] m;
        if (!e || !m_seeded || c == 4'h0) return 1'b0;
        if (c == 4'hF) return 1'b1;
        m = (16'h1 << c) - 16'h1;
        return ((ma ^ mb) & m) == 16'h0;
    endfunction

    // one clock: drive, predict, advance model, sample at negedge, compare
    task automatic step(input logic [3:0] c, input logic e, input logic ld,
                        input logic r, input string tag, output logic got);
        logic ef, ep;
        rate_code = c; en = e; load = ld; rst = r;
        ef = r ? 1'b0 : exp_fire(c, e);
        ep = r ? 1'b0 : (c == 4'hF);
        if (r) begin
            ma = 16'h0; mb = 16'h0; m_seeded = 1'b0;
        end else if (ld) begin
            ma = (seed_a == 16'h0) ? 16'hACE1 : seed_a;
            mb = (seed_b == 16'h0) ? 16'h5A3C : seed_b;
            m_seeded = 1'b1;
        end else begin
            ma = nxt(ma); mb = nxt(mb);
        end
        @(posedge clk);
        @(negedge clk);
        total++;
        if (fire !== ef || perm_mode !== ep) begin
            bad++;
            $display("FAIL %s: fire=%b perm_mode=%b expected fire=%b perm_mode=%b",
                     tag, fire, perm_mode, ef, ep);
        end
        got = fire;
    endtask

    task automatic count_check(input int got, input int lo, input int hi, input string tag);
        total++;
        if (got < lo || got > hi) begin
            bad++;
            $display("FAIL %s: count=%0d expected range %0d..%0d", tag, got, lo, hi);
        end
    endtask

    initial begin
        #(5.0 * 150000);
        bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic f;
        int   n;
        @(negedge clk);
        // R1: reset state
        for (int i = 0; i < 3; i++) step(4'hF, 1'b1, 1'b0, 1'b1, "R1 reset", f);
        // R1: no trigger before seeding, even in permanent mode
        for (int i = 0; i < 2; i++) step(4'hF, 1'b1, 1'b0, 1'b0, "R1 unseeded", f);
        seed_a = 16'hACE1; seed_b = 16'h1D2B;
        step(4'h1, 1'b1, 1'b1, 1'b0, "R2 load", f);

        // R4/R5/R2: rate table, exact per-cycle match plus windowed count
        for (int v = 0; v < NV; v++) begin
            n = 0;
            for (int k = 0; k < VECS[v].cycles; k++) begin
                step(VECS[v].code, 1'b1, 1'b0, 1'b0, "R4 sequence", f);
                n += int'(f);
            end
            count_check(n, VECS[v].lo, VECS[v].hi, "R5 rate count");
        end

        // R6: code 0 never fires
        n = 0;
        for (int k = 0; k < 500; k++) begin
            step(4'h0, 1'b1, 1'b0, 1'b0, "R6 off", f);
            n += int'(f);
        end
        count_check(n, 0, 0, "R6 off count");

        // R7: permanent mode fires every cycle and raises the flag
        n = 0;
        for (int k = 0; k < 200; k++) begin
            step(4'hF, 1'b1, 1'b0, 1'b0, "R7 perm", f);
            n += int'(f);
        end
        count_check(n, 200, 200, "R7 perm count");

        // R8: disable blocks triggers; generators keep advancing (checked after)
        n = 0;
        for (int k = 0; k < 300; k++) begin
            step(4'h1, 1'b0, 1'b0, 1'b0, "R8 disabled", f);
            n += int'(f);
        end
        count_check(n, 0, 0, "R8 disabled count");
        for (int k = 0; k < 200; k++) step(4'h1, 1'b1, 1'b0, 1'b0, "R8 advanced", f);

        // R9/R10: code changes every few cycles without reload
        for (int k = 0; k < 600; k++) begin
            step(4'((k / 3) % 16), 1'b1, 1'b0, 1'b0, "R9 code change", f);
        end

        // R3: zero seed on A picks up the default
        seed_a = 16'h0; seed_b = 16'h1234;
        step(4'h2, 1'b1, 1'b1, 1'b0, "R3 zero seed load", f);
        for (int k = 0; k < 400; k++) step(4'h1, 1'b1, 1'b0, 1'b0, "R3 default seed", f);

        // R1: mid-run reset clears outputs
        step(4'hF, 1'b1, 1'b0, 1'b1, "R1 mid reset", f);
        step(4'hF, 1'b1, 1'b0, 1'b0, "R1 after reset", f);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule